// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block resolves read-after-write data hazards for a five-stage, in-order integer pipeline (fetch, decode, execute, memory access, writeback). It watches the source register numbers of the instruction now in decode and the one now in execute. It compares them against the destination registers carried by the two pipeline registers that follow execute. From those comparisons it steers each ALU operand to the value that is newest: a bypass from the execute/memory register, a bypass from the memory/writeback register, or the register file.

A load result only exists once the memory stage has finished. An instruction that reads it from the slot right behind the load therefore cannot be served by a bypass. In that case the unit asserts a one-cycle interlock. The program counter and the fetch/decode register keep their contents, and a bubble enters the decode/execute register, while the load itself moves on.

The register file writes early in a cycle and reads late, so decode needs no bypass from writeback. Write-after-read and write-after-write cases cannot occur in this pipeline, because all reads happen in stage 2 and all writes in stage 5, and the unit does not look for them. All outputs are combinational functions of the present inputs.

Top module: `hzd_fwd_unit`

## Requirements
- R1: An operand select reads 2'b10 (bypass from execute/memory) when that stage writes a register, its destination is nonzero, and the destination equals the execute-stage source of that operand.
- R2: An operand select reads 2'b01 (bypass from memory/writeback) when that stage writes a nonzero destination equal to the operand's execute-stage source and the R1 condition does not hold for that operand.
- R3: When both later stages match the same source, the select is 2'b10, because the execute/memory value is the newer one.
- R4: With no qualifying match, including any match whose write-enable is low, the select is 2'b00 (register file).
- R5: Register 0 never produces a bypass select and never causes an interlock, even if a stage names it as its destination with write-enable high.
- R6: When execute holds a load that writes a nonzero destination equal to either decode-stage source, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in that same cycle.
- R7: A non-load producer in execute, or a load that has already reached execute/memory, does not raise any of the three interlock outputs.
- R8: A destination that matches another stage's destination without any source matching it (write-after-write), or an execute-stage destination equal to a decode source of a non-load, changes no output.
- R9: Neither select ever takes the value 2'b11.
- R10: The two operand selects are decided independently; each may take a different bypass source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src1 | input | AW | First source register of the decode-stage instruction |
| id_src2 | input | AW | Second source register of the decode-stage instruction |
| ex_src1 | input | AW | First source register of the execute-stage instruction (operand A) |
| ex_src2 | input | AW | Second source register of the execute-stage instruction (operand B) |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| xm_dst | input | AW | Destination held in the execute/memory register |
| xm_wr | input | 1 | Execute/memory instruction writes a register |
| mw_dst | input | AW | Destination held in the memory/writeback register |
| mw_wr | input | 1 | Memory/writeback instruction writes a register |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
The bench builds the unit with its defaults: 5-bit register numbers and register 0 hardwired. That brings all 32 register numbers within reach. Sweeps walk every nonzero number through the priority case and the interlock case, and register 0 is driven as a destination of every stage with write-enable high. A vector table mixes the cases that separate the two bypass sources, the disabled writes, loads one and two slots ahead, and pure destination collisions.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_MW  = 2'b01,
      FWD_XM  = 2'b10
   } fwd_sel_e;

   localparam int unsigned NUM_ALU_SRC = 2;

endpackage

// File: rtl/hzd_reg_match.sv
module hzd_reg_match #(
   parameter int unsigned AW          = 5,
   parameter bit          ZERO_REG_EN = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          dst_wr,
   output logic          hit
);

   logic same;
   assign same = (src == dst);

   generate
      if (ZERO_REG_EN) begin : g_zero_hardwired
         assign hit = dst_wr && same && (dst != '0);
      end else begin : g_zero_plain
         assign hit = dst_wr && same;
      end
   endgenerate

endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
   import hzd_pkg::*;
#(
   parameter int unsigned AW          = 5,
   parameter bit          ZERO_REG_EN = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] xm_dst,
   input  logic          xm_wr,
   input  logic [AW-1:0] mw_dst,
   input  logic          mw_wr,
   output fwd_sel_e      sel
);

   logic hit_xm;
   logic hit_mw;

   hzd_reg_match #(.AW(AW), .ZERO_REG_EN(ZERO_REG_EN)) u_match_xm (
      .src(src), .dst(xm_dst), .dst_wr(xm_wr), .hit(hit_xm)
   );

   hzd_reg_match #(.AW(AW), .ZERO_REG_EN(ZERO_REG_EN)) u_match_mw (
      .src(src), .dst(mw_dst), .dst_wr(mw_wr), .hit(hit_mw)
   );

   always_comb begin
      if (hit_xm)      sel = FWD_XM;
      else if (hit_mw) sel = FWD_MW;
      else             sel = FWD_RF;
   end

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
   parameter int unsigned AW          = 5,
   parameter bit          ZERO_REG_EN = 1'b1
) (
   input  logic [AW-1:0] id_src1,
   input  logic [AW-1:0] id_src2,
   input  logic [AW-1:0] ex_dst,
   input  logic          ex_wr,
   input  logic          ex_load,
   output logic          stall
);

   logic hit1;
   logic hit2;
   logic ld_wr;

   assign ld_wr = ex_wr && ex_load;

   hzd_reg_match #(.AW(AW), .ZERO_REG_EN(ZERO_REG_EN)) u_match_s1 (
      .src(id_src1), .dst(ex_dst), .dst_wr(ld_wr), .hit(hit1)
   );

   hzd_reg_match #(.AW(AW), .ZERO_REG_EN(ZERO_REG_EN)) u_match_s2 (
      .src(id_src2), .dst(ex_dst), .dst_wr(ld_wr), .hit(hit2)
   );

   assign stall = hit1 || hit2;

endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
   import hzd_pkg::*;
#(
   parameter int unsigned AW          = 5,
   parameter bit          ZERO_REG_EN = 1'b1
) (
   input  logic [AW-1:0] id_src1,
   input  logic [AW-1:0] id_src2,
   input  logic [AW-1:0] ex_src1,
   input  logic [AW-1:0] ex_src2,
   input  logic [AW-1:0] ex_dst,
   input  logic          ex_wr,
   input  logic          ex_load,
   input  logic [AW-1:0] xm_dst,
   input  logic          xm_wr,
   input  logic [AW-1:0] mw_dst,
   input  logic          mw_wr,
   output logic [1:0]    sel_a,
   output logic [1:0]    sel_b,
   output logic          pc_hold,
   output logic          ifid_hold,
   output logic          idex_bubble
);

   localparam int unsigned NSRC = NUM_ALU_SRC;

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("hzd_fwd_unit: AW must lie in 1..8");
      end
   endgenerate

   logic [AW-1:0] ex_src [NSRC];
   fwd_sel_e      sel    [NSRC];
   logic          stall;

   assign ex_src[0] = ex_src1;
   assign ex_src[1] = ex_src2;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_opnd
         hzd_fwd_sel #(.AW(AW), .ZERO_REG_EN(ZERO_REG_EN)) u_sel (
            .src(ex_src[i]),
            .xm_dst(xm_dst), .xm_wr(xm_wr),
            .mw_dst(mw_dst), .mw_wr(mw_wr),
            .sel(sel[i])
         );
      end
   endgenerate

   hzd_load_use #(.AW(AW), .ZERO_REG_EN(ZERO_REG_EN)) u_lu (
      .id_src1(id_src1), .id_src2(id_src2),
      .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
      .stall(stall)
   );

   assign sel_a       = sel[0];
   assign sel_b       = sel[1];
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

   // Immediate checks on the composed outputs, against port-level conditions.
   always_comb begin
      p_sel_legal_r9: assert (sel_a != 2'b11 && sel_b != 2'b11)
         else $error("select 11 produced");
      if (xm_wr && xm_dst != '0 && xm_dst == ex_src1)
         p_newest_first_r3: assert (sel_a == 2'b10)
            else $error("operand A did not take execute/memory bypass");
      if (ZERO_REG_EN && ex_src1 == '0)
         p_zero_fwd_r5: assert (sel_a == 2'b00)
            else $error("register 0 bypassed");
      if (!ex_load)
         p_nonload_nostall_r7: assert (!pc_hold && !idex_bubble)
            else $error("interlock without a load");
      if (idex_bubble)
         p_stall_cause_r6: assert (ex_wr && (ex_dst == id_src1 || ex_dst == id_src2))
            else $error("interlock without a matching load");
   end

endmodule

// File: tb/tb_hzd_fwd_unit.sv
module tb_hzd_fwd_unit;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW = 5;

   typedef struct packed {
      logic [4:0] i1, i2, e1, e2, ed;
      logic       ew, el;
      logic [4:0] md;
      logic       mwr;
      logic [4:0] wd;
      logic       wwr;
      logic [1:0] xa, xb;
      logic       xs;
      logic [3:0] tag;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      //    i1     i2     e1     e2     ed    ew    el    md    mwr   wd    wwr   xa     xb     xs    tag
      '{5'd0, 5'd0, 5'd3, 5'd4, 5'd7, 1'b1, 1'b0, 5'd3, 1'b1, 5'd9, 1'b1, 2'b10, 2'b00, 1'b0, 4'd1},  // R1
      '{5'd0, 5'd0, 5'd5, 5'd6, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 5'd6, 1'b1, 2'b00, 2'b01, 1'b0, 4'd2},  // R2
      '{5'd0, 5'd0, 5'd5, 5'd1, 5'd0, 1'b0, 1'b0, 5'd5, 1'b0, 5'd5, 1'b1, 2'b01, 2'b00, 1'b0, 4'd2},  // R2 disabled newer write
      '{5'd0, 5'd0, 5'd2, 5'd2, 5'd0, 1'b0, 1'b0, 5'd2, 1'b1, 5'd2, 1'b1, 2'b10, 2'b10, 1'b0, 4'd3},  // R3
      '{5'd0, 5'd0, 5'd12,5'd11,5'd0, 1'b0, 1'b0, 5'd11,1'b1, 5'd11,1'b1, 2'b00, 2'b10, 1'b0, 4'd3},  // R3 operand B
      '{5'd0, 5'd0, 5'd3, 5'd3, 5'd0, 1'b0, 1'b0, 5'd3, 1'b0, 5'd3, 1'b0, 2'b00, 2'b00, 1'b0, 4'd4},  // R4
      '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 4'd5},  // R5
      '{5'd4, 5'd1, 5'd1, 5'd1, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 4'd6},  // R6 src1
      '{5'd2, 5'd4, 5'd1, 5'd1, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 4'd6},  // R6 src2
      '{5'd4, 5'd0, 5'd1, 5'd1, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7},  // R7 non-load
      '{5'd4, 5'd0, 5'd9, 5'd1, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7},  // R7 load two ahead
      '{5'd1, 5'd2, 5'd1, 5'd2, 5'd6, 1'b1, 1'b1, 5'd6, 1'b1, 5'd6, 1'b1, 2'b00, 2'b00, 1'b0, 4'd8},  // R8 WAW only
      '{5'd0, 5'd0, 5'd7, 5'd8, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 5'd7, 1'b1, 2'b01, 2'b10, 1'b0, 4'd10}  // R10
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0] id_src1, id_src2, ex_src1, ex_src2, ex_dst, xm_dst, mw_dst;
   logic          ex_wr, ex_load, xm_wr, mw_wr;
   logic [1:0]    sel_a, sel_b;
   logic          pc_hold, ifid_hold, idex_bubble;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   hzd_fwd_unit dut (
      .id_src1(id_src1), .id_src2(id_src2),
      .ex_src1(ex_src1), .ex_src2(ex_src2),
      .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
      .xm_dst(xm_dst), .xm_wr(xm_wr),
      .mw_dst(mw_dst), .mw_wr(mw_wr),
      .sel_a(sel_a), .sel_b(sel_b),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
   );

   task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(posedge clk);
      id_src1 = v.i1; id_src2 = v.i2; ex_src1 = v.e1; ex_src2 = v.e2;
      ex_dst = v.ed; ex_wr = v.ew; ex_load = v.el;
      xm_dst = v.md; xm_wr = v.mwr; mw_dst = v.wd; mw_wr = v.wwr;
      @(negedge clk);
   endtask

   task automatic check_all(input string req, input vec_t v);
      chk(req, "sel_a", sel_a, v.xa);
      chk(req, "sel_b", sel_b, v.xb);
      chk(req, "pc_hold", {1'b0, pc_hold}, {1'b0, v.xs});
      chk(req, "ifid_hold", {1'b0, ifid_hold}, {1'b0, v.xs});
      chk(req, "idex_bubble", {1'b0, idex_bubble}, {1'b0, v.xs});
   endtask

   function automatic vec_t zero_vec();
      return '0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      vec_t v;
      v = zero_vec();
      drive(v);
      rst_n = 1'b1;
      // Idle state after reset: everything at register file, no interlock (R4).
      check_all("R4 idle", v);

      for (int k = 0; k < NV; k++) begin
         drive(VEC[k]);
         check_all($sformatf("R%0d vec%0d", VEC[k].tag, k), VEC[k]);
      end

      // R3 sweep: both later stages match every nonzero register.
      for (int r = 1; r < 32; r++) begin
         v = zero_vec();
         v.e1 = 5'(r); v.md = 5'(r); v.mwr = 1'b1; v.wd = 5'(r); v.wwr = 1'b1;
         v.xa = 2'b10;
         drive(v);
         chk("R3 sweep", "sel_a", sel_a, v.xa);
      end

      // R6 sweep: load in execute matching decode source, every nonzero register.
      for (int r = 1; r < 32; r++) begin
         v = zero_vec();
         v.i2 = 5'(r); v.i1 = 5'(32 - r); v.ed = 5'(r); v.ew = 1'b1; v.el = 1'b1;
         drive(v);
         chk("R6 sweep", "idex_bubble", {1'b0, idex_bubble}, 2'b01);
      end

      // R5: register 0 as load destination with a decode source of 0 on both.
      v = zero_vec();
      v.ew = 1'b1; v.el = 1'b1; v.mwr = 1'b1; v.wwr = 1'b1;
      drive(v);
      check_all("R5 zero load", v);

      // R8: non-load producer whose destination equals decode source, execute destination
      // equal to writeback destination: no select, no interlock.
      v = zero_vec();
      v.i1 = 5'd9; v.ed = 5'd9; v.ew = 1'b1; v.wd = 5'd9; v.wwr = 1'b1; v.e1 = 5'd3;
      drive(v);
      check_all("R8 name reuse", v);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule